// File: doc/BRIEF.md
# Two-Layer Stub Finder

This block looks at one bunch period of binary strip hits from two stacked sensor layers of 127 channels each. One layer is the seed layer and the other is the correlation layer. Adjacent hits in each layer are merged into clusters. A cluster that is too wide is dropped. Each remaining cluster is reduced to a centre position in half-strip units.

Every seed cluster then looks for a correlation cluster. The search covers a window of programmable half-width, and that window can be shifted by a signed offset. When a match is found, the block forms a stub. The stub carries the seed centre as its address and a bend code, which comes from a programmable table indexed by the seed-to-correlation displacement. The block reports up to three stubs per period in ascending address order. It also raises an overflow flag when more stubs exist, and gives an OR of all raw channel hits. A swap input exchanges the roles of the two layers. All outputs are registered and appear one clock after the hits are presented.

Top module: `stub_finder`

## Requirements
- R1: A cluster is a maximal run of adjacent hit channels within one layer. Its centre is first strip + last strip, in half-strips (0..252). A stub reports the seed cluster's centre as its 8-bit address.
- R2: A cluster whose run is longer than 4 strips yields no stub and cannot serve as a correlation partner.
- R3: A seed centre p matches a correlation centre q when |q - p - off| <= win. Here off is `win_off` read as a 4-bit two's-complement value, and win is the unsigned `win_half`, both in half-strips.
- R4: When several correlation centres match one seed, the one with the lowest q is used.
- R5: The bend is table entry e = clip(q - p, -7, +7) + 7. Entry e occupies `bend_lut[4e+3:4e]`.
- R6: Stubs fill slots 0, 1, 2 in ascending address. Slot k uses `stub_addr[8k+7:8k]` and `stub_bend[4k+3:4k]`, and `stub_valid[k]` flags it. Unused slots show valid 0, address 0 and bend 0.
- R7: `overflow` is 1 exactly when more than three stubs exist in the period. The three lowest addresses are still reported.
- R8: `hit_or` is the OR of all 254 raw hit inputs, including hits in vetoed clusters.
- R9: With `swap` = 1, `hits_b` is the seed layer and `hits_a` the correlation layer. With `swap` = 0 it is the reverse.
- R10: Outputs update on the clock edge after the inputs are applied. An active-low reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one edge per bunch period |
| rst_n | input | 1 | Active-low synchronous reset |
| hits_a | input | 127 | Inner-layer channel hits (seed unless swapped) |
| hits_b | input | 127 | Outer-layer channel hits (correlation unless swapped) |
| swap | input | 1 | Exchange seed and correlation roles |
| win_off | input | 4 | Signed window offset in half-strips |
| win_half | input | 3 | Window half-width in half-strips |
| bend_lut | input | 60 | Fifteen 4-bit bend codes |
| stub_valid | output | 3 | Per-slot stub valid |
| stub_addr | output | 24 | Three 8-bit half-strip addresses |
| stub_bend | output | 12 | Three 4-bit bend codes |
| overflow | output | 1 | More than three stubs found |
| hit_or | output | 1 | OR of all raw hits |

## Verification
Some properties are checked on every cycle: the slots fill from slot 0 with no gaps, valid addresses strictly ascend, empty slots read zero, overflow only appears with all three slots full, and no stub appears without a raw hit. The bench scenarios are what show the geometry itself. They cover the centre arithmetic for odd and even widths, the width veto, the window edges with positive and negative offsets, the lowest-partner choice, bend clipping, the layer swap, and the strips at both ends of the sensor.

// File: rtl/stub_finder.sv
module stub_finder #(
  parameter int NCH  = 127,
  parameter int MAXW = 4,
  parameter int AW   = 8,
  parameter int BW   = 4,
  parameter int DMAX = 7,
  parameter int OW   = 4,
  parameter int WW   = 3,
  parameter int NOUT = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        hits_a,
  input  logic [NCH-1:0]        hits_b,
  input  logic                  swap,
  input  logic [OW-1:0]         win_off,
  input  logic [WW-1:0]         win_half,
  input  logic [(2*DMAX+1)*BW-1:0] bend_lut,
  output logic [NOUT-1:0]       stub_valid,
  output logic [NOUT*AW-1:0]    stub_addr,
  output logic [NOUT*BW-1:0]    stub_bend,
  output logic                  overflow,
  output logic                  hit_or
);
  localparam int NHS  = 2*NCH - 1;
  localparam int WMAX = (1 << WW) - 1;
  localparam int SW   = $clog2(NOUT + 1);

  function automatic logic [NHS-1:0] centres(input logic [NCH-1:0] h);
    logic [NCH+MAXW+1:0] hx;
    logic [NHS-1:0] c;
    int run;
    logic alive;
    hx = {{(MAXW+1){1'b0}}, h, 1'b0};
    c = '0;
    for (int i = 0; i < NCH; i++) begin
      if (hx[i+1] && !hx[i]) begin
        run = 0;
        alive = 1'b1;
        for (int j = 0; j <= MAXW; j++) begin
          if (alive && hx[i+j+1]) run++;
          else alive = 1'b0;
        end
        if (run <= MAXW) c[2*i+run-1] = 1'b1;
      end
    end
    return c;
  endfunction

  logic [NHS-1:0] cen_a, cen_b, seed_c, corr_c;
  assign cen_a  = centres(hits_a);
  assign cen_b  = centres(hits_b);
  assign seed_c = swap ? cen_b : cen_a;
  assign corr_c = swap ? cen_a : cen_b;

  logic [NHS-1:0] sv;
  logic [BW-1:0]  sb [NHS];

  always_comb begin
    int off, q, d, kabs;
    off = int'($signed(win_off));
    for (int p = 0; p < NHS; p++) begin
      sv[p] = 1'b0;
      d = 0;
      for (int k = WMAX; k >= -WMAX; k--) begin
        q = p + off + k;
        kabs = (k < 0) ? -k : k;
        if (seed_c[p] && kabs <= int'(win_half) && q >= 0 && q < NHS) begin
          if (corr_c[q[AW-1:0]]) begin
            sv[p] = 1'b1;
            d = off + k;
          end
        end
      end
      if (d > DMAX) d = DMAX;
      if (d < -DMAX) d = -DMAX;
      sb[p] = sv[p] ? bend_lut[(d+DMAX)*BW +: BW] : '0;
    end
  end

  logic [NOUT-1:0]    val_n;
  logic [NOUT*AW-1:0] addr_n;
  logic [NOUT*BW-1:0] bend_n;
  logic               ov_n;

  always_comb begin
    int cnt;
    cnt = 0;
    val_n = '0;
    addr_n = '0;
    bend_n = '0;
    for (int p = 0; p < NHS; p++) begin
      if (sv[p]) begin
        if (cnt < NOUT) begin
          val_n[cnt[SW-1:0]] = 1'b1;
          addr_n[cnt*AW +: AW] = p[AW-1:0];
          bend_n[cnt*BW +: BW] = sb[p];
        end
        cnt++;
      end
    end
    ov_n = (cnt > NOUT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stub_valid <= '0;
      stub_addr  <= '0;
      stub_bend  <= '0;
      overflow   <= 1'b0;
      hit_or     <= 1'b0;
    end else begin
      stub_valid <= val_n;
      stub_addr  <= addr_n;
      stub_bend  <= bend_n;
      overflow   <= ov_n;
      hit_or     <= |{hits_a, hits_b};
    end
  end

  for (genvar k = 1; k < NOUT; k++) begin : g_slot_chk
    // R6
    slot_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stub_valid[k] |-> stub_valid[k-1]);
    // R6
    addr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stub_valid[k] |-> (stub_addr[k*AW +: AW] > stub_addr[(k-1)*AW +: AW]));
  end

  for (genvar k = 0; k < NOUT; k++) begin : g_empty_chk
    // R6
    empty_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stub_valid[k] |-> (stub_addr[k*AW +: AW] == '0 && stub_bend[k*BW +: BW] == '0));
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (&stub_valid));

  // R8
  hit_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_or |-> (stub_valid == '0 && !overflow));
endmodule

// File: tb/stub_finder_tb.sv
module stub_finder_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic [126:0] hits_a = '0, hits_b = '0;
  logic swap = 0;
  logic [3:0] win_off = '0;
  logic [2:0] win_half = '0;
  logic [59:0] bend_lut;
  logic [2:0] stub_valid;
  logic [23:0] stub_addr;
  logic [11:0] stub_bend;
  logic overflow, hit_or;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  stub_finder u_dut (.clk(clk), .rst_n(rst_n), .hits_a(hits_a), .hits_b(hits_b),
    .swap(swap), .win_off(win_off), .win_half(win_half), .bend_lut(bend_lut),
    .stub_valid(stub_valid), .stub_addr(stub_addr), .stub_bend(stub_bend),
    .overflow(overflow), .hit_or(hit_or));

  // seed first, seed width, corr first, corr width, offset, window, exp valid, exp addr, exp bend
  localparam int NV = 11;
  localparam int VEC [NV][9] = '{
    '{10, 1, 11, 1,  0, 3, 1,  20,  6},
    '{10, 2, 10, 1,  0, 2, 1,  21,  9},
    '{10, 5, 12, 1,  0, 7, 0,   0,  0},
    '{10, 4, 12, 4,  0, 3, 0,   0,  0},
    '{10, 4, 12, 4,  0, 4, 1,  23,  4},
    '{30, 1, 33, 1,  6, 0, 1,  60,  2},
    '{50, 1, 47, 1, -6, 0, 1, 100, 14},
    '{ 0, 1,  0, 1,  0, 0, 1,   0,  8},
    '{126,1,126, 1,  0, 0, 1, 252,  8},
    '{10, 1, 14, 1,  7, 2, 1,  20,  1},
    '{10, 3, 10, 3,  0, 0, 1,  22,  8}
  };

  function automatic logic [126:0] run(input int first, input int width);
    logic [126:0] v = '0;
    for (int i = 0; i < width; i++) v[first+i] = 1'b1;
    return v;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8*100000);
    fails++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int e = 0; e < 15; e++) bend_lut[e*4 +: 4] = 4'(15 - e);
    hits_a = run(10, 1);
    hits_b = run(10, 1);
    @(negedge clk);
    @(negedge clk);
    // R10 reset clears outputs
    chk("R10 reset valid", int'(stub_valid), 0);
    chk("R10 reset hit_or", int'(hit_or), 0);
    chk("R10 reset addr", int'(stub_addr), 0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      hits_a = run(VEC[i][0], VEC[i][1]);
      hits_b = run(VEC[i][2], VEC[i][3]);
      win_off = 4'(VEC[i][4]);
      win_half = 3'(VEC[i][5]);
      step();
      // R1 R2 R3 R5 table rows
      chk($sformatf("R3 row%0d valid", i), int'(stub_valid[0]), VEC[i][6]);
      chk($sformatf("R1 row%0d addr", i), int'(stub_addr[7:0]), VEC[i][7]);
      chk($sformatf("R5 row%0d bend", i), int'(stub_bend[3:0]), VEC[i][8]);
      chk($sformatf("R6 row%0d upper", i), int'(stub_valid[2:1]), 0);
      chk($sformatf("R8 row%0d hit_or", i), int'(hit_or), 1);
    end

    // R2 wide correlation cluster vetoed
    hits_a = run(20, 1); hits_b = run(18, 5); win_off = 0; win_half = 7;
    step();
    chk("R2 wide corr", int'(stub_valid), 0);

    // R4 lowest partner
    hits_a = run(20, 1); hits_b = run(19, 1) | run(21, 1); win_half = 3;
    step();
    chk("R4 lowest q bend", int'(stub_bend[3:0]), 10);

    // R9 swap
    hits_a = run(11, 1); hits_b = run(10, 1); swap = 1;
    step();
    chk("R9 swap addr", int'(stub_addr[7:0]), 20);
    chk("R9 swap bend", int'(stub_bend[3:0]), 6);
    swap = 0;
    step();
    chk("R9 noswap addr", int'(stub_addr[7:0]), 22);
    chk("R9 noswap bend", int'(stub_bend[3:0]), 10);

    // R6 R7 four stubs
    hits_a = run(5,1) | run(20,1) | run(40,1) | run(60,1);
    hits_b = hits_a; win_half = 0;
    step();
    chk("R7 overflow set", int'(overflow), 1);
    chk("R6 slots valid", int'(stub_valid), 7);
    chk("R6 slot addrs", int'(stub_addr), (80 << 16) | (40 << 8) | 10);
    chk("R6 slot bends", int'(stub_bend), 12'h888);

    // R7 exactly three
    hits_a = run(5,1) | run(20,1) | run(40,1); hits_b = hits_a;
    step();
    chk("R7 three no overflow", int'(overflow), 0);
    chk("R7 three valid", int'(stub_valid), 7);

    // R8 no hits
    hits_a = '0; hits_b = '0;
    step();
    chk("R8 no hits", int'(hit_or), 0);
    chk("R6 empty", int'(stub_valid), 0);

    // R10 reset mid-run
    hits_a = run(10, 1); hits_b = run(10, 1); rst_n = 0;
    step();
    chk("R10 reset again", int'(stub_valid), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule